// File: doc/BRIEF.md
# Integer ALU with Zero Detect

This block is the combinational integer datapath of a small load/store processor. It takes two 32-bit operands and a 3-bit operation select. It returns a 32-bit result and three flags: a zero flag, a carry-out and a signed overflow flag. The supported operations are bitwise AND, bitwise OR, addition, subtraction and signed set-on-less-than.

A single carry-lookahead adder serves addition, subtraction and set-on-less-than. For subtraction the second operand is inverted and the carry-in is forced to one, which adds the two's complement negative of B. Set-on-less-than takes the sign of the difference and corrects it with the signed overflow. Its answer is therefore right even when A minus B does not fit in 32 bits.

The block holds no state. Outputs follow the inputs within the same cycle, and the instruction decode of the surrounding pipeline drives the operation select.

Top module: `alu_zd`

## Requirements
- R1: Operation code 3'b000 drives the result with A AND B, bit by bit.
- R2: Operation code 3'b001 drives the result with A OR B, bit by bit.
- R3: Operation code 3'b010 drives the result with the low 32 bits of A+B, and carry-out with bit 32 of that unsigned sum.
- R4: Operation code 3'b110 drives the result with A + ~B + 1 (that is, A−B modulo 2^32), and carry-out with bit 32 of that 33-bit sum. Carry-out is therefore 1 exactly when A ≥ B as unsigned numbers.
- R5: For add and subtract, overflow is 1 exactly when the two addends that reach the adder (A and B, or A and −B) share a sign and the result's bit 31 differs from that sign.
- R6: Operation code 3'b111 drives result bit 0 with 1 when A < B as signed two's complement numbers, and with 0 otherwise. Bits 31..1 are 0.
- R7: Set-on-less-than stays correct when A−B overflows, for example with A = 32'h8000_0000 and B = 1, or with A = 32'h7FFF_FFFF and B = 32'hFFFF_FFFF.
- R8: For the five valid operation codes, zero is 1 exactly when all 32 result bits are 0.
- R9: Operation codes 3'b011, 3'b100 and 3'b101 drive a result of 0 with zero, carry-out and overflow all 0.
- R10: Carry-out and overflow are 0 for AND, OR and set-on-less-than.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand |
| op_i | input | 3 | Operation select |
| result_o | output | 32 | Operation result |
| zero_o | output | 1 | Result is all zeros (valid codes only) |
| carry_o | output | 1 | Adder carry-out (add and subtract only) |
| ovf_o | output | 1 | Signed overflow (add and subtract only) |

## Verification
The hardest case to reach from the ports is a set-on-less-than whose internal difference overflows. Here the raw sign bit of the adder gives the wrong answer, and only the overflow correction makes the result right. Random operands seldom hit the extreme-magnitude pairs that cause this. The directed set-on-less-than task therefore pairs the most negative and most positive values with small values of the opposite sign, and a pseudo-random sweep then covers the general cases. Subtraction that overflows and a zero result from each operation are also built deliberately from chosen operand pairs.

// File: rtl/alu_zd_pkg.sv
// Shared operation encoding for the integer ALU.
// Assumes a 3-bit operation select driven by the instruction decoder.
package alu_zd_pkg;
    typedef enum logic [2:0] {
        OP_AND = 3'b000,
        OP_OR  = 3'b001,
        OP_ADD = 3'b010,
        OP_SUB = 3'b110,
        OP_SLT = 3'b111
    } alu_op_e;
endpackage

// File: rtl/alu_zd_cla.sv
// Grouped carry-lookahead adder.
// Each group of GROUP bits forms a group generate/propagate pair, so the
// carry hops from group to group; inside a group the carry ripples.
// Assumes WIDTH is a multiple of GROUP.
// Also returns the carry into the top bit so the caller can form overflow.
module alu_zd_cla #(
    parameter int WIDTH = 32,
    parameter int GROUP = 4
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             cin_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             cout_o,
    output logic             cmsb_o
);
    localparam int NGRP = WIDTH / GROUP;

    logic [WIDTH-1:0] gen_b;
    logic [WIDTH-1:0] prop_b;
    logic [WIDTH-1:0] carry_in_b;
    logic [NGRP:0]    grp_c;

    assign gen_b    = a_i & b_i;
    assign prop_b   = a_i ^ b_i;
    assign grp_c[0] = cin_i;

    for (genvar k = 0; k < NGRP; k++) begin : g_grp
        logic             grp_g;
        logic             grp_p;
        logic [GROUP-1:0] loc_c;

        // Fold the bit generate/propagate terms into one group pair.
        always_comb begin
            grp_g = 1'b0;
            grp_p = 1'b1;
            for (int i = 0; i < GROUP; i++) begin
                grp_g = gen_b[k*GROUP+i] | (prop_b[k*GROUP+i] & grp_g);
                grp_p = grp_p & prop_b[k*GROUP+i];
            end
        end

        assign grp_c[k+1] = grp_g | (grp_p & grp_c[k]);
        assign loc_c[0]   = grp_c[k];

        for (genvar i = 0; i < GROUP; i++) begin : g_bit
            if (i > 0) begin : g_rip
                assign loc_c[i] = gen_b[k*GROUP+i-1] | (prop_b[k*GROUP+i-1] & loc_c[i-1]);
            end
            assign carry_in_b[k*GROUP+i] = loc_c[i];
            assign sum_o[k*GROUP+i]      = prop_b[k*GROUP+i] ^ loc_c[i];
        end
    end

    assign cout_o = grp_c[NGRP];
    assign cmsb_o = carry_in_b[WIDTH-1];
endmodule

// File: rtl/alu_zd_logic.sv
// Bitwise logic unit: AND or OR of the two operands.
// Assumes the caller qualifies the output with the operation decode.
module alu_zd_logic #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             use_or_i,
    output logic [WIDTH-1:0] out_o
);
    // Pick the bitwise function.
    always_comb begin
        out_o = use_or_i ? (a_i | b_i) : (a_i & b_i);
    end
endmodule

// File: rtl/alu_zd_zero.sv
// Zero detector, gated by a valid-operation qualifier.
// Assumes the value is already the final selected result.
module alu_zd_zero #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] value_i,
    input  logic             valid_i,
    output logic             zero_o
);
    // Flag an all-zero value only for a decoded operation.
    always_comb begin
        zero_o = valid_i & ~(|value_i);
    end
endmodule

// File: rtl/alu_zd.sv
// Combinational integer ALU with zero detect.
// One adder serves add, subtract and set-on-less-than. Subtraction inverts
// B and forces carry-in high. Set-on-less-than uses the difference sign
// XOR signed overflow. Undecoded operation codes give a zero result and
// clear every flag. No clock and no state.
module alu_zd #(
    parameter int WIDTH = 32,
    parameter int GROUP = 4
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic [2:0]       op_i,
    output logic [WIDTH-1:0] result_o,
    output logic             zero_o,
    output logic             carry_o,
    output logic             ovf_o
);
    import alu_zd_pkg::*;

    logic             do_sub;
    logic             op_valid;
    logic [WIDTH-1:0] b_eff;
    logic [WIDTH-1:0] sum;
    logic             add_cout;
    logic             add_cmsb;
    logic             add_ovf;
    logic             less;
    logic [WIDTH-1:0] logic_out;

    // Decode subtraction use and operation validity.
    always_comb begin
        do_sub   = (op_i == OP_SUB) || (op_i == OP_SLT);
        op_valid = (op_i == OP_AND) || (op_i == OP_OR) || (op_i == OP_ADD) ||
                   (op_i == OP_SUB) || (op_i == OP_SLT);
        b_eff    = b_i ^ {WIDTH{do_sub}};
    end

    alu_zd_cla #(.WIDTH(WIDTH), .GROUP(GROUP)) u_add (
        .a_i    (a_i),
        .b_i    (b_eff),
        .cin_i  (do_sub),
        .sum_o  (sum),
        .cout_o (add_cout),
        .cmsb_o (add_cmsb)
    );

    alu_zd_logic #(.WIDTH(WIDTH)) u_logic (
        .a_i      (a_i),
        .b_i      (b_i),
        .use_or_i (op_i[0]),
        .out_o    (logic_out)
    );

    // Overflow from the carries at the top bit; less-than from corrected sign.
    always_comb begin
        add_ovf = add_cout ^ add_cmsb;
        less    = sum[WIDTH-1] ^ add_ovf;
    end

    // Select the result and qualify the adder flags.
    always_comb begin
        result_o = '0;
        carry_o  = 1'b0;
        ovf_o    = 1'b0;
        case (op_i)
            OP_AND, OP_OR: result_o = logic_out;
            OP_ADD, OP_SUB: begin
                result_o = sum;
                carry_o  = add_cout;
                ovf_o    = add_ovf;
            end
            OP_SLT:  result_o = {{(WIDTH-1){1'b0}}, less};
            default: result_o = '0;
        endcase
    end

    alu_zd_zero #(.WIDTH(WIDTH)) u_zero (
        .value_i (result_o),
        .valid_i (op_valid),
        .zero_o  (zero_o)
    );
endmodule

// File: rtl/alu_zd_chk.sv
// Property checker for the ALU, bound to every instance of alu_zd.
// Checks port relations with immediate assertions, since the block has no clock.
module alu_zd_chk #(
    parameter int WIDTH = 32
) (
    input logic [WIDTH-1:0] a_i,
    input logic [WIDTH-1:0] b_i,
    input logic [2:0]       op_i,
    input logic [WIDTH-1:0] result_o,
    input logic             zero_o,
    input logic             carry_o,
    input logic             ovf_o
);
    logic is_valid;
    logic is_adder;

    // Classify the operation code.
    always_comb begin
        is_valid = (op_i == 3'b000) || (op_i == 3'b001) || (op_i == 3'b010) ||
                   (op_i == 3'b110) || (op_i == 3'b111);
        is_adder = (op_i == 3'b010) || (op_i == 3'b110);
    end

    // Check port relations after every input change.
    always_comb begin
        AST_ADD_INVERSE: assert (op_i != 3'b010 || (result_o - b_i) == a_i) else $error("add result"); // R3
        AST_SUB_INVERSE: assert (op_i != 3'b110 || (result_o + b_i) == a_i) else $error("sub result"); // R4
        AST_OVF_SIGN: assert (!(op_i == 3'b010 && ovf_o) || (a_i[WIDTH-1] == b_i[WIDTH-1] && result_o[WIDTH-1] != a_i[WIDTH-1])) else $error("ovf sign"); // R5
        AST_SLT_BINARY: assert (op_i != 3'b111 || result_o[WIDTH-1:1] == '0) else $error("slt width"); // R6
        AST_ZERO_MATCH: assert (!is_valid || zero_o == (result_o == '0)) else $error("zero flag"); // R8
        AST_UNUSED_QUIET: assert (is_valid || (result_o == '0 && !zero_o && !carry_o && !ovf_o)) else $error("unused code"); // R9
        AST_NONADD_FLAGS: assert (is_adder || (!carry_o && !ovf_o)) else $error("flags outside add/sub"); // R10
    end
endmodule

bind alu_zd alu_zd_chk #(.WIDTH(WIDTH)) u_alu_zd_chk (
    .a_i      (a_i),
    .b_i      (b_i),
    .op_i     (op_i),
    .result_o (result_o),
    .zero_o   (zero_o),
    .carry_o  (carry_o),
    .ovf_o    (ovf_o)
);

// File: tb/test_alu_zd.sv
// Directed bench for alu_zd: one task per scenario, each checking its vectors.
module test_alu_zd;
    logic        clk;
    logic [31:0] a;
    logic [31:0] b;
    logic [2:0]  op;
    logic [31:0] result;
    logic        zero;
    logic        carry;
    logic        ovf;

    int applied;
    int miscompares;
    bit done;

    alu_zd i_alu_zd (
        .a_i      (a),
        .b_i      (b),
        .op_i     (op),
        .result_o (result),
        .zero_o   (zero),
        .carry_o  (carry),
        .ovf_o    (ovf)
    );

    initial clk = 1'b0;
    always #10 clk = ~clk;   // 50 MHz

    // Reference model written from the requirements.
    function automatic void model(input logic [31:0] x, input logic [31:0] y,
                                  input logic [2:0] o, output logic [31:0] r,
                                  output logic z, output logic c, output logic v);
        logic [32:0] wide;
        logic        valid;
        r = '0; c = 1'b0; v = 1'b0; valid = 1'b1;
        case (o)
            3'b000: r = x & y;                                       // R1
            3'b001: r = x | y;                                       // R2
            3'b010: begin                                            // R3
                wide = {1'b0, x} + {1'b0, y};
                r = wide[31:0]; c = wide[32];
                v = (x[31] == y[31]) && (r[31] != x[31]);            // R5
            end
            3'b110: begin                                            // R4
                wide = {1'b0, x} + {1'b0, ~y} + 33'd1;
                r = wide[31:0]; c = wide[32];
                v = (x[31] != y[31]) && (r[31] != x[31]);            // R5
            end
            3'b111: r = ($signed(x) < $signed(y)) ? 32'd1 : 32'd0;   // R6 R7
            default: valid = 1'b0;                                   // R9
        endcase
        z = valid && (r == '0);                                      // R8
    endfunction

    // Drive on the falling edge, compare midway to the rising edge.
    task automatic apply(input logic [31:0] x, input logic [31:0] y,
                         input logic [2:0] o, input string req);
        logic [31:0] er;
        logic ez, ec, ev;
        @(negedge clk);
        a = x; b = y; op = o;
        #5;
        model(x, y, o, er, ez, ec, ev);
        applied++;
        if (result !== er || zero !== ez || carry !== ec || ovf !== ev) begin
            miscompares++;
            $display("FAIL %s op=%b a=%h b=%h: got r=%h z=%b c=%b v=%b, want r=%h z=%b c=%b v=%b",
                     req, o, x, y, result, zero, carry, ovf, er, ez, ec, ev);
        end
    endtask

    task automatic t_start_state();
        apply(32'h0, 32'h0, 3'b000, "R8 initial all-zero AND");
    endtask

    task automatic t_logic();
        apply(32'hF0F0_A5A5, 32'hFF00_0F0F, 3'b000, "R1 AND");
        apply(32'hFFFF_FFFF, 32'h1234_5678, 3'b000, "R1 AND ones");
        apply(32'hAAAA_AAAA, 32'h5555_5555, 3'b000, "R1 R8 AND to zero");
        apply(32'hF0F0_0000, 32'h0000_0F0F, 3'b001, "R2 OR");
        apply(32'h0, 32'h0, 3'b001, "R2 R8 OR zero");
        apply(32'hFFFF_FFFF, 32'hFFFF_FFFF, 3'b001, "R2 R10 OR no flags");
    endtask

    task automatic t_add();
        apply(32'd7, 32'd6, 3'b010, "R3 small add");
        apply(32'hFFFF_FFFF, 32'd1, 3'b010, "R3 R8 carry wrap to zero");
        apply(32'h7FFF_FFFF, 32'd1, 3'b010, "R5 positive overflow");
        apply(32'h8000_0000, 32'h8000_0000, 3'b010, "R5 negative overflow");
        apply(32'h0000_FFFF, 32'h0000_0001, 3'b010, "R3 group carry chain");
    endtask

    task automatic t_sub();
        apply(32'd7, 32'd6, 3'b110, "R4 7-6");
        apply(32'd6, 32'd7, 3'b110, "R4 borrow");
        apply(32'h1234_5678, 32'h1234_5678, 3'b110, "R4 R8 equal operands");
        apply(32'h8000_0000, 32'd1, 3'b110, "R5 sub overflow");
        apply(32'h7FFF_FFFF, 32'hFFFF_FFFF, 3'b110, "R5 sub overflow positive");
        apply(32'h0, 32'h8000_0000, 3'b110, "R5 negate min");
    endtask

    task automatic t_slt();
        apply(32'hFFFF_FFFF, 32'd1, 3'b111, "R6 -1 < 1");
        apply(32'd1, 32'hFFFF_FFFF, 3'b111, "R6 R8 1 < -1 false");
        apply(32'd5, 32'd5, 3'b111, "R6 equal");
        apply(32'h8000_0000, 32'd1, 3'b111, "R7 min < 1 overflowing diff");
        apply(32'h7FFF_FFFF, 32'hFFFF_FFFF, 3'b111, "R7 max < -1 overflowing diff");
        apply(32'h7FFF_FFFF, 32'h8000_0000, 3'b111, "R7 max vs min");
        apply(32'h8000_0000, 32'h7FFF_FFFF, 3'b111, "R7 min vs max R10");
    endtask

    task automatic t_unused();
        apply(32'hFFFF_FFFF, 32'd1, 3'b011, "R9 code 011");
        apply(32'h0, 32'h0, 3'b100, "R9 code 100 zero flag clear");
        apply(32'h8000_0000, 32'h8000_0000, 3'b101, "R9 code 101");
    endtask

    task automatic t_sweep();
        logic [31:0] lfsr;
        lfsr = 32'hACE1_2345;
        for (int n = 0; n < 400; n++) begin
            logic [31:0] x;
            logic [2:0]  o;
            x    = lfsr;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            o    = lfsr[2:0];
            apply(x, lfsr ^ 32'h5A5A_0F0F, o, "R1 R2 R3 R4 R6 R9 sweep");
        end
    endtask

    initial begin
        applied = 0; miscompares = 0; done = 1'b0;
        a = '0; b = '0; op = 3'b000;
        t_start_state();
        t_logic();
        t_add();
        t_sub();
        t_slt();
        t_unused();
        t_sweep();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: got timeout, want completion");
            $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
            $finish;
        end
    end
endmodule